// File: doc/BRIEF.md
# VID Reference Slew Controller

This block turns the voltage-identification code driven by a processor into the digital code for an on-chip reference DAC. It reads the VID lines once per sample tick, which is derived from the system clock by a fixed divider. A new code is taken only once the same value has been read on a set number of back-to-back samples. A single varying read starts the count over. Until the first code is taken, the DAC code rests at zero.

A mode pin picks the response to a taken code. In jump mode the DAC code is set to the taken code on the same edge. In walk mode the DAC code moves one LSB on each step tick toward the taken code. A large VID change then becomes a timed ramp whose length is the step count times the step period. The step tick is a free-running division of the sample tick. A busy flag is high while the DAC code and the taken code differ.

Top module: `vid_slew_ctrl`

## Requirements
- R1: While reset is held, and afterwards until the first code is accepted, `dac_code` is 0 and `busy` is 0.
- R2: Sample ticks fall on every `SAMPLE_DIV`-th rising edge after reset release. A code is accepted at the sample tick where it has been read on `STABLE_CNT` consecutive samples. Any differing sample restarts the run, so a code held for fewer samples never reaches `dac_code`.
- R3: The first accepted code after reset is loaded into `dac_code` on the same edge, whatever the mode.
- R4: With `mode_slew` = 0 (jump mode), `dac_code` equals the accepted code on the edge where that code is accepted. Any older difference is closed on the next edge.
- R5: With `mode_slew` = 1 (walk mode), `dac_code` changes only on step ticks, by exactly one toward the accepted code. Step ticks fall on every `STEP_DIV`-th sample tick counted from reset, whether a walk is in progress or not.
- R6: If a new code is accepted during a walk, the walk continues from the present `dac_code` toward the new code, without a reload.
- R7: After the first acceptance, `busy` is 1 exactly when `dac_code` differs from the last accepted code.
- R8: In walk mode, the total time to settle is the step distance times `STEP_DIV`·`SAMPLE_DIV` cycles, give or take one step period, after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_in | input | VID_W | VID code from the processor |
| mode_slew | input | 1 | 0 = jump to accepted code, 1 = walk one LSB per step tick |
| dac_code | output | VID_W | Code for the reference DAC |
| busy | output | 1 | DAC code has not yet reached the accepted code |

## Verification
The bench builds the block with `SAMPLE_DIV` = 2, `STEP_DIV` = 3 and `STABLE_CNT` = 3. A sample then takes two cycles and a walk step takes six. A full-range ramp of dozens of LSBs, and retargets in the middle of a walk, therefore fit into a few hundred cycles. Short glitches of one and two samples exercise the restart of the stability run.

// File: rtl/vid_slew_ctrl.sv
module vid_slew_ctrl #(
  parameter int VID_W      = 6,
  parameter int SAMPLE_DIV = 16,
  parameter int STABLE_CNT = 3,
  parameter int STEP_DIV   = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VID_W-1:0] vid_in,
  input  logic             mode_slew,
  output logic [VID_W-1:0] dac_code,
  output logic             busy
);
  localparam int SW = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
  localparam int TW = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
  localparam int RW = $clog2(STABLE_CNT + 1);

  logic [SW-1:0]    scnt;
  logic [TW-1:0]    stcnt;
  logic [RW-1:0]    run;
  logic [VID_W-1:0] cand;
  logic [VID_W-1:0] target;
  logic             valid;
  logic             samp_tick, step_tick, same, accept;

  assign samp_tick = (scnt == SW'(SAMPLE_DIV - 1));
  assign step_tick = samp_tick && (stcnt == TW'(STEP_DIV - 1));
  assign same      = (run != '0) && (vid_in == cand);
  assign accept    = samp_tick && same && (run == RW'(STABLE_CNT - 1));
  assign busy      = valid && (dac_code != target);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scnt  <= '0;
      stcnt <= '0;
    end else begin
      scnt <= samp_tick ? '0 : scnt + 1'b1;
      if (samp_tick) stcnt <= step_tick ? '0 : stcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= '0;
      cand <= '0;
    end else if (samp_tick) begin
      cand <= vid_in;
      if (!same)                         run <= RW'(1);
      else if (run != RW'(STABLE_CNT))   run <= run + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      target   <= '0;
      valid    <= 1'b0;
      dac_code <= '0;
    end else begin
      if (accept) begin
        target <= vid_in;
        valid  <= 1'b1;
      end
      if (accept && !valid)
        dac_code <= vid_in;
      else if (valid && !mode_slew)
        dac_code <= accept ? vid_in : target;
      else if (valid && step_tick && dac_code != target)
        dac_code <= (dac_code < target) ? dac_code + 1'b1 : dac_code - 1'b1;
    end
  end
endmodule

// File: rtl/vid_slew_ctrl_chk.sv
module vid_slew_ctrl_chk #(
  parameter int VID_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_slew,
  input logic [VID_W-1:0] dac_code,
  input logic             busy,
  input logic [VID_W-1:0] target,
  input logic             valid,
  input logic             samp_tick,
  input logic             step_tick
);
  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (dac_code == '0 && !busy));

  assert_busy_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> valid);

  assert_first_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> (dac_code == target));

  assert_accept_on_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && $past(valid) && target != $past(target)) |-> $past(samp_tick));

  assert_jump_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && $past(valid) && $past(!mode_slew)) |-> (dac_code == target));

  assert_hold_between_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && mode_slew && !step_tick) |=> $stable(dac_code));

  assert_one_lsb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && mode_slew) |=> (dac_code - $past(dac_code) == VID_W'(0) ||
                               dac_code - $past(dac_code) == VID_W'(1) ||
                               $past(dac_code) - dac_code == VID_W'(1)));
endmodule

bind vid_slew_ctrl vid_slew_ctrl_chk #(.VID_W(VID_W)) u_chk (.*);

// File: tb/vid_slew_ctrl_tb.sv
module vid_slew_ctrl_tb;
  localparam int W = 6, SD = 2, SC = 3, ST = 3;

  logic clk = 1'b0, rst_n = 1'b0, mode = 1'b0;
  logic [W-1:0] vid = '0;
  logic [W-1:0] dac;
  logic busy;
  int checks = 0, errors = 0;
  string tag = "R1";
  bit done = 0;

  vid_slew_ctrl #(.VID_W(W), .SAMPLE_DIV(SD), .STABLE_CNT(SC), .STEP_DIV(ST)) u_dut (
    .clk(clk), .rst_n(rst_n), .vid_in(vid), .mode_slew(mode), .dac_code(dac), .busy(busy));

  always #2.5 clk = ~clk;

  // reference model: sample history, tick counting from reset
  int cyc, k, nh;
  logic [W-1:0] h[4];
  logic [W-1:0] m_tgt, m_dac;
  bit m_val;

  function automatic bit run_hits_limit(int n, logic [W-1:0] a, logic [W-1:0] b,
                                        logic [W-1:0] c, logic [W-1:0] d);
    if (n < SC) return 0;
    if (!(a == b && b == c)) return 0;
    return (n == SC) || (d != c);
  endfunction

  function automatic logic [W-1:0] toward(logic [W-1:0] cur, logic [W-1:0] goal);
    if (cur < goal) return cur + 1'b1;
    if (cur > goal) return cur - 1'b1;
    return cur;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0; k = 0; nh = 0; m_val = 0; m_tgt = '0; m_dac = '0;
      for (int i = 0; i < 4; i++) h[i] = '0;
    end else begin
      bit acc, stp;
      acc = 0; stp = 0;
      cyc++;
      if (cyc % SD == 0) begin
        k++;
        h[3] = h[2]; h[2] = h[1]; h[1] = h[0]; h[0] = vid;
        if (nh < 4) nh++;
        acc = run_hits_limit(nh, h[0], h[1], h[2], h[3]);
        stp = (k % ST == 0);
      end
      if (acc && !m_val) m_dac = vid;
      else if (m_val && !mode) m_dac = acc ? vid : m_tgt;
      else if (m_val && stp) m_dac = toward(m_dac, m_tgt);
      if (acc) begin m_tgt = vid; m_val = 1; end
    end
  end

  task automatic check(string t, logic [W-1:0] got, logic [W-1:0] exp, logic gb, logic eb);
    checks++;
    if (got !== exp || gb !== eb) begin
      errors++;
      $display("FAIL %s dac=%0d busy=%0b expected dac=%0d busy=%0b", t, got, gb, exp, eb);
    end
  endtask

  always @(negedge clk)
    if (!done) check(tag, dac, m_dac, busy, m_val && (m_dac != m_tgt));

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    process::self().srandom(32'd1234);
    wait_n(4);
    check("R1", dac, '0, busy, 1'b0);
    vid = 6'd20;
    rst_n = 1'b1;
    wait_n(3);
    tag = "R1";
    check("R1", dac, '0, busy, 1'b0);
    wait_n(10);
    tag = "R3";
    check("R3", dac, 6'd20, busy, 1'b0);

    tag = "R2";
    vid = 6'd21; wait_n(2 * SD);
    vid = 6'd20; wait_n(10 * SD);
    check("R2", dac, 6'd20, busy, 1'b0);
    vid = 6'd33; wait_n(SD);
    vid = 6'd20; wait_n(10 * SD);
    check("R2", dac, 6'd20, busy, 1'b0);

    tag = "R4";
    vid = 6'd45; wait_n(4 * SD);
    check("R4", dac, 6'd45, busy, 1'b0);
    for (int i = 0; i < 20; i++) begin
      vid = (($urandom % 2) == 0) ? vid + 1'b1 : vid - 1'b1;
      wait_n(4 * SD + ($urandom % 4));
    end

    tag = "R5";
    mode = 1'b1;
    vid = 6'd10; wait_n(4 * SD);
    check("R7", dac, m_dac, busy, 1'b1);
    wait_n(45 * SD * ST);
    tag = "R8";
    check("R8", dac, 6'd10, busy, 1'b0);

    tag = "R6";
    vid = 6'd60; wait_n(4 * SD + 20 * SD * ST);
    vid = 6'd25; wait_n(60 * SD * ST);
    check("R6", dac, 6'd25, busy, 1'b0);

    tag = "R7";
    for (int i = 0; i < 40; i++) begin
      if ($urandom % 5 == 0) mode = ~mode;
      vid = W'($urandom);
      wait_n(1 + ($urandom % 40));
    end
    mode = 1'b0;
    wait_n(4 * SD);
    check("R4", dac, vid, busy, 1'b0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule